// File: doc/BRIEF.md
# Controller Halt and Global Reset Sequencer

This block is the control engine that brings a network controller's datapath to a safe stop and puts it through a global reset. A one-cycle stop request first checks a sticky "halted" flag. If the controller is already halted, the request finishes at once with a false result. Otherwise the flag is set, and the block then runs a fixed sequence:

- masks every interrupt source by writing all ones to the mask-clear port;
- drops the receive and transmit enables;
- lets a drain interval pass;
- fires a self-clearing global reset, which also loads the general-purpose pin direction and value registers with their initial pattern;
- waits a settle interval;
- masks interrupts a second time;
- issues one read strobe to the pending-cause register so that latched causes clear;
- pulses done.

The result returned with done is the level of the reset bit as sampled at the end of the settle interval. A true result therefore means the reset failed to clear itself. The reset bit drops after its programmed pulse width, but only once the datapath stops holding it through `rst_hold_i`. A start request given while the sequencer is idle clears the halted flag and re-enables receive and transmit, so a later stop can run again. All interfaces are plain control and status pins. None of them carries a data stream, so there is no back-pressure.

Top module: `nic_halt_seq`

## Requirements
- R1: After reset: `halted_o`=0, `rx_en_o`=`tx_en_o`=1, `grst_o`=0, `gp_dir_o`=`gp_val_o`=0, and `done_o`, `imc_wr_o`, `icr_rd_o` all 0.
- R2: A stop request accepted while idle with the halted flag set gives `done_o`=1 and `result_o`=0 in the next cycle. It does not change the enables, the reset line, the pins or the strobes.
- R3: Cycle numbering: cycle 1 is the cycle after the clock edge that accepts a stop request with the flag clear. `halted_o` is 1 from cycle 1 on and stays 1 until a start request is accepted.
- R4: `imc_wr_o` is high, with `imc_data_o` all ones, in exactly cycles 1 and PRE_CYC+POST_CYC+2. In every other cycle `imc_data_o` is zero.
- R5: `rx_en_o` and `tx_en_o` are 0 from cycle 2 on. `grst_o` first rises in cycle PRE_CYC+2.
- R6: With `rst_hold_i` low, `grst_o` is high for exactly RST_CYC cycles. While `rst_hold_i` is high, `grst_o` stays high, and it falls one cycle after the hold drops.
- R7: From cycle PRE_CYC+2 on, `gp_dir_o`=4'b1111 and `gp_val_o`=4'b1101 (bit 3 down to bit 0). These values hold until the next reset.
- R8: `icr_rd_o` is high in exactly cycle PRE_CYC+POST_CYC+3.
- R9: `done_o` pulses in cycle PRE_CYC+POST_CYC+4. `result_o` then equals the level of `grst_o` in cycle PRE_CYC+POST_CYC+1.
- R10: Stop and start requests that arrive while a sequence is running are ignored. The sequence timing is unchanged, and `halted_o` stays 1.
- R11: A start request while idle gives `halted_o`=0 and `rx_en_o`=`tx_en_o`=1 in the next cycle. If stop and start arrive together, start wins and no sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop request pulse |
| start_i | input | 1 | Start request: clears halted flag, re-enables datapath |
| rst_hold_i | input | 1 | Datapath holds the global reset bit set |
| halted_o | output | 1 | Sticky halted flag |
| rx_en_o | output | 1 | Receive unit enable |
| tx_en_o | output | 1 | Transmit unit enable |
| imc_wr_o | output | 1 | Interrupt mask-clear write strobe |
| imc_data_o | output | IRQ_W | Mask-clear write data |
| grst_o | output | 1 | Self-clearing global reset |
| gp_dir_o | output | 4 | General-purpose pin directions (1 = output) |
| gp_val_o | output | 4 | General-purpose pin values |
| icr_rd_o | output | 1 | Pending interrupt cause read strobe |
| done_o | output | 1 | Sequence completion pulse |
| result_o | output | 1 | Reset bit read back; valid with done_o |

## Verification
The bench builds the block with PRE_CYC=5, POST_CYC=8 and RST_CYC=3. With these values the reset pulse clears well inside the settle window, so the false result is reached without the hold. The true result is reached by holding `rst_hold_i`. The drain interval is long enough that stray stop and start pulses can be placed inside it. The short delays keep each sequence within about twenty cycles, which leaves room for many random mixes of start, stop, hold and stray requests, together with directed cases for the already-halted path and a simultaneous start and stop.

// File: rtl/nic_halt_pkg.sv
package nic_halt_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_MASK_PRE,
    HS_DRAIN,
    HS_SETTLE,
    HS_MASK_POST,
    HS_READ_CAUSE,
    HS_FIN
  } halt_state_e;

  localparam int unsigned GP_PINS = 4;
  localparam logic [GP_PINS-1:0] GP_DIR_INIT = 4'b1111;
  localparam logic [GP_PINS-1:0] GP_VAL_INIT = 4'b1101;

endpackage

// File: rtl/halt_delay.sv
module halt_delay #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/self_clr_rst.sv
module self_clr_rst #(
  parameter int unsigned PULSE = 3,
  parameter int unsigned CW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic hold_i,
  output logic rst_o
);
  localparam logic [CW-1:0] LOADV = CW'(PULSE - 1);

  logic          bit_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else if (fire_i) begin
      bit_q <= 1'b1;
      cnt_q <= LOADV;
    end else if (bit_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!hold_i) begin
        bit_q <= 1'b0;
      end
    end
  end

  assign rst_o = bit_q;
endmodule

// File: rtl/gp_init_reg.sv
module gp_init_reg
  import nic_halt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  output logic [GP_PINS-1:0] dir_o,
  output logic [GP_PINS-1:0] val_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
      val_o <= '0;
    end else if (load_i) begin
      dir_o <= GP_DIR_INIT;
      val_o <= GP_VAL_INIT;
    end
  end
endmodule

// File: rtl/nic_halt_seq.sv
module nic_halt_seq
  import nic_halt_pkg::*;
#(
  parameter int unsigned IRQ_W    = 32,
  parameter int unsigned PRE_CYC  = 5,
  parameter int unsigned POST_CYC = 8,
  parameter int unsigned RST_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             start_i,
  input  logic             rst_hold_i,
  output logic             halted_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             imc_wr_o,
  output logic [IRQ_W-1:0] imc_data_o,
  output logic             grst_o,
  output logic [3:0]       gp_dir_o,
  output logic [3:0]       gp_val_o,
  output logic             icr_rd_o,
  output logic             done_o,
  output logic             result_o
);
  localparam int unsigned MAX_A = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int unsigned MAX_V = (MAX_A > RST_CYC) ? MAX_A : RST_CYC;
  localparam int unsigned CW    = $clog2(MAX_V + 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] POST_LD = CW'(POST_CYC - 1);

  halt_state_e state_q;
  logic        halted_q, rx_en_q, tx_en_q, result_q;
  logic        tmr_load, tmr_run, tmr_zero, fire_rst;
  logic [CW-1:0] tmr_val;

  assign fire_rst = (state_q == HS_DRAIN) && tmr_zero;
  assign tmr_load = (state_q == HS_MASK_PRE) || fire_rst;
  assign tmr_val  = (state_q == HS_MASK_PRE) ? PRE_LD : POST_LD;
  assign tmr_run  = (state_q == HS_DRAIN) || (state_q == HS_SETTLE);

  halt_delay #(.CW(CW)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .run_i     (tmr_run),
    .zero_o    (tmr_zero)
  );

  self_clr_rst #(.PULSE(RST_CYC), .CW(CW)) u_grst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire_i(fire_rst),
    .hold_i(rst_hold_i),
    .rst_o (grst_o)
  );

  gp_init_reg u_gp (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(fire_rst),
    .dir_o (gp_dir_o),
    .val_o (gp_val_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HS_IDLE;
      halted_q <= 1'b0;
      rx_en_q  <= 1'b1;
      tx_en_q  <= 1'b1;
      result_q <= 1'b0;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (start_i) begin
            halted_q <= 1'b0;
            rx_en_q  <= 1'b1;
            tx_en_q  <= 1'b1;
          end else if (stop_i) begin
            if (halted_q) begin
              result_q <= 1'b0;
              state_q  <= HS_FIN;
            end else begin
              halted_q <= 1'b1;
              state_q  <= HS_MASK_PRE;
            end
          end
        end
        HS_MASK_PRE: begin
          rx_en_q <= 1'b0;
          tx_en_q <= 1'b0;
          state_q <= HS_DRAIN;
        end
        HS_DRAIN: begin
          if (tmr_zero) state_q <= HS_SETTLE;
        end
        HS_SETTLE: begin
          if (tmr_zero) begin
            result_q <= grst_o;
            state_q  <= HS_MASK_POST;
          end
        end
        HS_MASK_POST:  state_q <= HS_READ_CAUSE;
        HS_READ_CAUSE: state_q <= HS_FIN;
        HS_FIN:        state_q <= HS_IDLE;
        default:       state_q <= HS_IDLE;
      endcase
    end
  end

  assign halted_o   = halted_q;
  assign rx_en_o    = rx_en_q;
  assign tx_en_o    = tx_en_q;
  assign imc_wr_o   = (state_q == HS_MASK_PRE) || (state_q == HS_MASK_POST);
  assign imc_data_o = {IRQ_W{imc_wr_o}};
  assign icr_rd_o   = (state_q == HS_READ_CAUSE);
  assign done_o     = (state_q == HS_FIN);
  assign result_o   = result_q;
endmodule

// File: rtl/nic_halt_seq_chk.sv
module nic_halt_seq_chk #(
  parameter int unsigned IRQ_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halted_o,
  input logic             rx_en_o,
  input logic             tx_en_o,
  input logic             imc_wr_o,
  input logic [IRQ_W-1:0] imc_data_o,
  input logic             grst_o,
  input logic [3:0]       gp_dir_o,
  input logic [3:0]       gp_val_o,
  input logic             icr_rd_o,
  input logic             done_o
);
  assert_mask_all_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    imc_wr_o |-> (imc_data_o == {IRQ_W{1'b1}}));

  assert_mask_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !imc_wr_o |-> (imc_data_o == '0));

  assert_reset_after_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grst_o) |-> (!rx_en_o && !tx_en_o && $past(!rx_en_o)));

  assert_gp_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grst_o |-> (gp_dir_o == 4'b1111 && gp_val_o == 4'b1101));

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(icr_rd_o && (imc_wr_o || done_o)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_when_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> halted_o);
endmodule

bind nic_halt_seq nic_halt_seq_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted_o  (halted_o),
  .rx_en_o   (rx_en_o),
  .tx_en_o   (tx_en_o),
  .imc_wr_o  (imc_wr_o),
  .imc_data_o(imc_data_o),
  .grst_o    (grst_o),
  .gp_dir_o  (gp_dir_o),
  .gp_val_o  (gp_val_o),
  .icr_rd_o  (icr_rd_o),
  .done_o    (done_o)
);

// File: tb/nic_halt_seq_tb.sv
module nic_halt_seq_tb;
  localparam int IRQ_W = 32;
  localparam int PRE   = 5;
  localparam int POST  = 8;
  localparam int RSTW  = 3;
  localparam int SEQ_L = PRE + POST + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_i = 1'b0, start_i = 1'b0, rst_hold_i = 1'b0;
  logic halted_o, rx_en_o, tx_en_o, imc_wr_o, grst_o, icr_rd_o, done_o, result_o;
  logic [IRQ_W-1:0] imc_data_o;
  logic [3:0] gp_dir_o, gp_val_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit exp_halted = 1'b0;
  bit exp_en = 1'b1;
  bit exp_gp = 1'b0;

  always #5 clk = ~clk;

  nic_halt_seq #(.IRQ_W(IRQ_W), .PRE_CYC(PRE), .POST_CYC(POST), .RST_CYC(RSTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .start_i(start_i), .rst_hold_i(rst_hold_i),
    .halted_o(halted_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .imc_wr_o(imc_wr_o),
    .imc_data_o(imc_data_o), .grst_o(grst_o), .gp_dir_o(gp_dir_o), .gp_val_o(gp_val_o),
    .icr_rd_o(icr_rd_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit f_imc(input int k);
    return (k == 1) || (k == PRE + POST + 2);
  endfunction
  function automatic bit f_grst(input int k, input bit hold);
    return (k >= PRE + 2) && (hold || (k <= PRE + 1 + RSTW));
  endfunction
  function automatic bit f_en(input int k, input bit prior);
    return (k < 2) ? prior : 1'b0;
  endfunction
  function automatic bit f_result(input bit hold);
    return hold || (RSTW >= POST);
  endfunction

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    exp_halted = 1'b0; exp_en = 1'b1;
    chk("R11", "halted after start", {31'd0, halted_o}, 32'd0);
    chk("R11", "rx_en after start", {31'd0, rx_en_o}, 32'd1);
    chk("R11", "tx_en after start", {31'd0, tx_en_o}, 32'd1);
  endtask

  task automatic do_stop(input bit hold, input bit stray_stop, input bit stray_start);
    bit prior_en;
    prior_en = exp_en;
    @(negedge clk) begin stop_i = 1'b1; rst_hold_i = hold; end
    @(negedge clk) stop_i = 1'b0;
    if (exp_halted) begin
      chk("R2", "done on halted stop", {31'd0, done_o}, 32'd1);
      chk("R2", "result on halted stop", {31'd0, result_o}, 32'd0);
      chk("R2", "imc untouched", {31'd0, imc_wr_o}, 32'd0);
      chk("R2", "grst untouched", {31'd0, grst_o}, 32'd0);
      chk("R2", "rx_en untouched", {31'd0, rx_en_o}, {31'd0, exp_en});
      chk("R2", "gp_dir untouched", {28'd0, gp_dir_o}, exp_gp ? 32'hF : 32'h0);
      @(negedge clk);
      chk("R2", "done single", {31'd0, done_o}, 32'd0);
      rst_hold_i = 1'b0;
      return;
    end
    for (int k = 1; k <= SEQ_L; k++) begin
      bit gpset;
      gpset = exp_gp || (k >= PRE + 2);
      chk("R3", "halted", {31'd0, halted_o}, 32'd1);
      chk("R4", "imc_wr", {31'd0, imc_wr_o}, {31'd0, f_imc(k)});
      chk("R4", "imc_data", imc_data_o, f_imc(k) ? 32'hFFFF_FFFF : 32'h0);
      chk("R5", "rx_en", {31'd0, rx_en_o}, {31'd0, f_en(k, prior_en)});
      chk("R5", "tx_en", {31'd0, tx_en_o}, {31'd0, f_en(k, prior_en)});
      chk("R6", "grst", {31'd0, grst_o}, {31'd0, f_grst(k, hold)});
      chk("R7", "gp_dir", {28'd0, gp_dir_o}, gpset ? 32'hF : 32'h0);
      chk("R7", "gp_val", {28'd0, gp_val_o}, gpset ? 32'hD : 32'h0);
      chk("R8", "icr_rd", {31'd0, icr_rd_o}, {31'd0, (k == PRE + POST + 3)});
      chk("R9", "done", {31'd0, done_o}, {31'd0, (k == SEQ_L)});
      if (k == SEQ_L)
        chk("R9", "result", {31'd0, result_o}, {31'd0, f_result(hold)});
      if (k == 3) begin stop_i = stray_stop; start_i = stray_start; end
      if (k == 4) begin stop_i = 1'b0; start_i = 1'b0; end
      @(negedge clk);
    end
    exp_halted = 1'b1; exp_en = 1'b0; exp_gp = 1'b1;
    chk("R10", "halted after busy requests", {31'd0, halted_o}, 32'd1);
    chk("R10", "no restart", {31'd0, imc_wr_o}, 32'd0);
    if (hold) begin
      chk("R6", "grst held", {31'd0, grst_o}, 32'd1);
      rst_hold_i = 1'b0;
      @(negedge clk);
      chk("R6", "grst after hold drop", {31'd0, grst_o}, 32'd0);
    end
    rst_hold_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "halted reset", {31'd0, halted_o}, 32'd0);
    chk("R1", "rx_en reset", {31'd0, rx_en_o}, 32'd1);
    chk("R1", "tx_en reset", {31'd0, tx_en_o}, 32'd1);
    chk("R1", "grst reset", {31'd0, grst_o}, 32'd0);
    chk("R1", "gp reset", {24'd0, gp_dir_o, gp_val_o}, 32'd0);
    chk("R1", "strobes reset", {29'd0, done_o, imc_wr_o, icr_rd_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {30'd0, done_o, grst_o}, 32'd0);

    // R11: simultaneous start and stop while not halted -> start wins
    @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
    chk("R11", "no sequence on start+stop", {31'd0, imc_wr_o}, 32'd0);
    chk("R11", "halted stays clear", {31'd0, halted_o}, 32'd0);

    do_stop(1'b0, 1'b0, 1'b0);   // plain sequence
    do_stop(1'b0, 1'b0, 1'b0);   // R2: already halted
    do_start();
    do_stop(1'b1, 1'b1, 1'b1);   // held reset, stray requests (R10)
    // R11: start+stop while halted -> cleared, no sequence
    @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
    exp_halted = 1'b0; exp_en = 1'b1;
    chk("R11", "start wins while halted", {31'd0, halted_o}, 32'd0);
    chk("R11", "no done on start+stop", {31'd0, done_o}, 32'd0);

    for (int i = 0; i < 40; i++) begin
      int op;
      op = $urandom_range(0, 3);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (op == 0) do_start();
      else do_stop(1'(($urandom_range(0, 3)) == 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule